// File: doc/BRIEF.md
# Stack Save/Restore and Register-Pair Move Sequencer

This block follows the instruction decoder of a small 32-bit RISC core. It accepts one 16-bit compressed instruction from a fixed group of instructions and expands it into single-cycle steps. The group has four save/restore forms and two register-pair moves. The save/restore forms are push, pop, pop-then-return, and pop-then-zero-then-return. The steps are stack-relative word stores or loads, register writes, a final stack-pointer update and, for the return forms, a jump to the restored return address.

The block drives one read port and one write port of the register file and a one-word memory port. It holds its current step while the memory signals a stall. A new instruction is taken only after every step of the previous one has finished. A reserved register-list value, or an instruction outside the group, is refused with a one-cycle illegal flag and has no side effects.

Top module: `pushpop_seq`

## Requirements
- R1: Accepted encodings have instr[1:0]=10 and instr[15:13]=101. Save/restore forms have instr[12:11]=11 and instr[8]=0, and instr[10:9] selects 00 push, 01 pop, 10 pop-return-zero, 11 pop-return. The list field L=instr[7:4] selects 13 registers when L=15 and L-3 registers otherwise. Registers join in the order x1, x8, x9, x18..x25, and x26 with x27 join together at the 13-register count. A push or pop makes exactly one memory access per selected register.
- R2: The stack adjustment is a base plus 16 times instr[3:2]. The base is 16 for 1-4 registers, 32 for 5-8, 48 for 9-11 and 64 for 13.
- R3: Push stores the selected registers from highest index to lowest. The first store goes to SP-4 and each later one is 4 bytes lower. x2 is then written with SP minus the adjustment.
- R4: Pop loads the selected registers from highest index to lowest. The first load comes from SP+adjustment-4 and each later one is 4 bytes lower. x2 is then written with SP plus the adjustment.
- R5: Pop-return-zero writes 0 to x10 after the restore.
- R6: Both return forms redirect to the value of x1 loaded by that same instruction.
- R7: A 3-bit saved-register selector r maps to x(r+8) for r<2 and to x(r+16) otherwise. The first selector is instr[9:7] and the second is instr[4:2].
- R8: Moves have instr[12:10]=011 and instr[5]=1. With instr[6]=0, x10 is copied to the first selected register and x11 to the second. With instr[6]=1, the first selected register is copied to x10 and the second to x11. Both sources are read before either destination is written.
- R9: A save/restore form with L below 4, or any encoding outside the group, raises the illegal output for the accept cycle only. It makes no memory access and no register write.
- R10: While the memory stall input is high, the pending access holds its address and direction and does not advance.
- R11: in_ready is high only when no step is pending. Nothing is written or accessed while it is high, and x0 is never written.
- R12: The redirect is the last step of a return form; in_ready rises in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Sequencer idle, instruction taken this cycle if valid |
| in_instr | input | 16 | Compressed instruction |
| illegal | output | 1 | Offered instruction refused |
| rf_raddr | output | 5 | Register read index |
| rf_rdata | input | XLEN | Register read data, same cycle |
| rf_we | output | 1 | Register write enable |
| rf_waddr | output | 5 | Register write index |
| rf_wdata | output | XLEN | Register write data |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a store |
| mem_addr | output | XLEN | Byte address of the word |
| mem_wdata | output | XLEN | Store data |
| mem_rdata | input | XLEN | Load data, valid in a non-stalled request cycle |
| mem_stall | input | 1 | Memory not ready, hold the access |
| redir_valid | output | 1 | Jump request |
| redir_target | output | XLEN | Jump address |

## Verification
Two cases are hard to reach from the ports. One is a return whose restored x1 differs from the x1 held before the pop. The other is a walk that is frozen in the middle of its access list. Before every pop and move, the bench overwrites all registers except x0 and x2 with fresh values, so a redirect to a stale x1 or a wrong restore order shows up as a mismatch. A second pass replays save/restore pairs while a pseudo-random stall pattern freezes the memory port on arbitrary steps. The number of completed accesses and the final contents must still match the model.

// File: rtl/pps_pkg.sv
package pps_pkg;

  localparam int RIDX_W = 5;

  localparam logic [RIDX_W-1:0] RI_RA = 5'd1;
  localparam logic [RIDX_W-1:0] RI_SP = 5'd2;
  localparam logic [RIDX_W-1:0] RI_A0 = 5'd10;
  localparam logic [RIDX_W-1:0] RI_A1 = 5'd11;

  typedef enum logic [2:0] {
    OP_PUSH, OP_POP, OP_POPRET, OP_POPRETZ, OP_MVSA, OP_MVAS
  } op_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_SPRD, ST_WALK, ST_SPWR, ST_ZERO, ST_JUMP,
    ST_RDA, ST_RDB, ST_WRA, ST_WRB
  } st_e;

  // membership of register idx in a list of n registers (fixed join order)
  function automatic logic in_list(input int idx, input logic [3:0] n);
    if (idx == 1)                   return n >= 4'd1;
    else if (idx == 8)              return n >= 4'd2;
    else if (idx == 9)              return n >= 4'd3;
    else if (idx >= 18 && idx <= 25) return 32'(n) >= idx - 14;
    else if (idx == 26 || idx == 27) return n == 4'd13;
    else                            return 1'b0;
  endfunction

  function automatic logic [RIDX_W-1:0] sreg_map(input logic [2:0] raw);
    return (raw[2:1] == 2'b00) ? {2'b01, raw} : {2'b10, raw};
  endfunction

endpackage

// File: rtl/pps_decode.sv
module pps_decode
  import pps_pkg::*;
#(
  parameter int NREG  = 32,
  parameter int ADJ_W = 8
) (
  input  logic [15:0]       instr,
  output logic              legal,
  output op_e               op,
  output logic [NREG-1:0]   mask,
  output logic [ADJ_W-1:0]  adj,
  output logic [RIDX_W-1:0] sel_a,
  output logic [RIDX_W-1:0] sel_b
);

  logic       fam, is_pp, is_mv;
  logic [3:0] lst, nregs;
  logic [6:0] base;

  assign fam   = (instr[1:0] == 2'b10) && (instr[15:13] == 3'b101);
  assign is_pp = fam && (instr[12:11] == 2'b11) && !instr[8];
  assign is_mv = fam && (instr[12:10] == 3'b011) && instr[5];
  assign lst   = instr[7:4];
  assign nregs = (lst == 4'hF) ? 4'd13 : lst - 4'd3;
  assign legal = (is_pp && (lst >= 4'd4)) || is_mv;

  always_comb begin
    if (is_mv) begin
      op = instr[6] ? OP_MVAS : OP_MVSA;
    end else begin
      case (instr[10:9])
        2'b00:   op = OP_PUSH;
        2'b01:   op = OP_POP;
        2'b10:   op = OP_POPRETZ;
        default: op = OP_POPRET;
      endcase
    end
  end

  for (genvar b = 0; b < NREG; b++) begin : g_mask
    assign mask[b] = in_list(b, nregs);
  end

  always_comb begin
    if (nregs > 4'd12)      base = 7'd64;
    else if (nregs > 4'd8)  base = 7'd48;
    else if (nregs > 4'd4)  base = 7'd32;
    else                    base = 7'd16;
  end

  assign adj   = ADJ_W'(base) + ADJ_W'({instr[3:2], 4'b0000});
  assign sel_a = sreg_map(instr[9:7]);
  assign sel_b = sreg_map(instr[4:2]);

endmodule

// File: rtl/pps_hibit.sv
module pps_hibit #(
  parameter int N = 32,
  parameter int W = $clog2(N)
) (
  input  logic [N-1:0] vec,
  output logic [W-1:0] idx
);

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (vec[i]) idx = W'(i);
    end
  end

endmodule

// File: rtl/pushpop_seq.sv
module pushpop_seq
  import pps_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int ADJ_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [15:0]       in_instr,
  output logic              illegal,
  output logic [4:0]        rf_raddr,
  input  logic [XLEN-1:0]   rf_rdata,
  output logic              rf_we,
  output logic [4:0]        rf_waddr,
  output logic [XLEN-1:0]   rf_wdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [XLEN-1:0]   mem_addr,
  output logic [XLEN-1:0]   mem_wdata,
  input  logic [XLEN-1:0]   mem_rdata,
  input  logic              mem_stall,
  output logic              redir_valid,
  output logic [XLEN-1:0]   redir_target
);

  localparam int NREG = 1 << RIDX_W;
  localparam logic [XLEN-1:0] WB = XLEN'(XLEN / 8);

  // decode
  logic              dec_legal;
  op_e               dec_op;
  logic [NREG-1:0]   dec_mask;
  logic [ADJ_W-1:0]  dec_adj;
  logic [RIDX_W-1:0] dec_sa, dec_sb;

  pps_decode #(.NREG(NREG), .ADJ_W(ADJ_W)) u_dec (
    .instr (in_instr),
    .legal (dec_legal),
    .op    (dec_op),
    .mask  (dec_mask),
    .adj   (dec_adj),
    .sel_a (dec_sa),
    .sel_b (dec_sb)
  );

  // state
  st_e               st_q, st_d;
  op_e               op_q;
  logic [NREG-1:0]   mask_q, mask_d;
  logic [ADJ_W-1:0]  adj_q;
  logic [RIDX_W-1:0] sa_q, sb_q;
  logic [XLEN-1:0]   sp_q, addr_q, addr_d, ra_q, hold_a_q, hold_b_q;
  logic              mask_en, addr_en, sp_en, ra_en, ha_en, hb_en, load;

  logic [RIDX_W-1:0] cur;
  logic [NREG-1:0]   remain;
  logic              accept, step, is_push, last;
  logic [XLEN-1:0]   adjx;
  logic [RIDX_W-1:0] src_a, src_b, dst_a, dst_b;

  pps_hibit #(.N(NREG), .W(RIDX_W)) u_pick (
    .vec (mask_q),
    .idx (cur)
  );

  assign in_ready = (st_q == ST_IDLE);
  assign accept   = in_ready && in_valid;
  assign illegal  = accept && !dec_legal;
  assign load     = accept && dec_legal;
  assign is_push  = (op_q == OP_PUSH);
  assign adjx     = XLEN'(adj_q);
  assign step     = (st_q == ST_WALK) && !mem_stall;
  assign remain   = mask_q & ~(NREG'(1) << cur);
  assign last     = (remain == '0);

  assign src_a = (op_q == OP_MVSA) ? RI_A0 : sa_q;
  assign src_b = (op_q == OP_MVSA) ? RI_A1 : sb_q;
  assign dst_a = (op_q == OP_MVSA) ? sa_q  : RI_A0;
  assign dst_b = (op_q == OP_MVSA) ? sb_q  : RI_A1;

  // next state
  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (load) st_d = (dec_op == OP_MVSA || dec_op == OP_MVAS) ? ST_RDA : ST_SPRD;
      ST_SPRD: st_d = ST_WALK;
      ST_WALK: if (step && last) st_d = ST_SPWR;
      ST_SPWR: begin
        if (op_q == OP_POPRETZ)     st_d = ST_ZERO;
        else if (op_q == OP_POPRET) st_d = ST_JUMP;
        else                        st_d = ST_IDLE;
      end
      ST_ZERO: st_d = ST_JUMP;
      ST_JUMP: st_d = ST_IDLE;
      ST_RDA:  st_d = ST_RDB;
      ST_RDB:  st_d = ST_WRA;
      ST_WRA:  st_d = ST_WRB;
      ST_WRB:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  // datapath enables and next values
  always_comb begin
    mask_en = load || step;
    mask_d  = load ? dec_mask : remain;
    sp_en   = (st_q == ST_SPRD);
    addr_en = sp_en || step;
    if (sp_en) addr_d = is_push ? rf_rdata - WB : rf_rdata + adjx - WB;
    else       addr_d = addr_q - WB;
    ra_en   = step && !is_push && (cur == RI_RA);
    ha_en   = (st_q == ST_RDA);
    hb_en   = (st_q == ST_RDB);
  end

  always_ff @(posedge clk) begin
    if (load) begin
      op_q  <= dec_op;
      adj_q <= dec_adj;
      sa_q  <= dec_sa;
      sb_q  <= dec_sb;
    end
    if (mask_en) mask_q   <= mask_d;
    if (sp_en)   sp_q     <= rf_rdata;
    if (addr_en) addr_q   <= addr_d;
    if (ra_en)   ra_q     <= mem_rdata;
    if (ha_en)   hold_a_q <= rf_rdata;
    if (hb_en)   hold_b_q <= rf_rdata;
  end

  // register-file read port
  always_comb begin
    case (st_q)
      ST_SPRD: rf_raddr = RI_SP;
      ST_WALK: rf_raddr = cur;
      ST_RDA:  rf_raddr = src_a;
      ST_RDB:  rf_raddr = src_b;
      default: rf_raddr = '0;
    endcase
  end

  // register-file write port
  always_comb begin
    rf_we    = 1'b0;
    rf_waddr = '0;
    rf_wdata = '0;
    case (st_q)
      ST_WALK: begin
        rf_we    = step && !is_push;
        rf_waddr = cur;
        rf_wdata = mem_rdata;
      end
      ST_SPWR: begin
        rf_we    = 1'b1;
        rf_waddr = RI_SP;
        rf_wdata = is_push ? sp_q - adjx : sp_q + adjx;
      end
      ST_ZERO: begin
        rf_we    = 1'b1;
        rf_waddr = RI_A0;
      end
      ST_WRA: begin
        rf_we    = 1'b1;
        rf_waddr = dst_a;
        rf_wdata = hold_a_q;
      end
      ST_WRB: begin
        rf_we    = 1'b1;
        rf_waddr = dst_b;
        rf_wdata = hold_b_q;
      end
      default: ;
    endcase
  end

  // memory port and redirect
  assign mem_req      = (st_q == ST_WALK);
  assign mem_we       = mem_req && is_push;
  assign mem_addr     = addr_q;
  assign mem_wdata    = rf_rdata;
  assign redir_valid  = (st_q == ST_JUMP);
  assign redir_target = ra_q;

endmodule

// File: rtl/pushpop_seq_chk.sv
module pushpop_seq_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_ready,
  input logic            illegal,
  input logic            mem_req,
  input logic            mem_we,
  input logic [XLEN-1:0] mem_addr,
  input logic            mem_stall,
  input logic            rf_we,
  input logic [4:0]      rf_waddr,
  input logic            redir_valid
);

  a_r10_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_stall |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  // R3 and R4: successive accesses of one walk step down by one word
  a_r3_descend: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_stall |=> !mem_req || (mem_addr == $past(mem_addr) - XLEN'(XLEN / 8)));

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !mem_req && !rf_we && !redir_valid);

  a_r11_no_x0: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> rf_waddr != 5'd0);

  a_r9_illegal_stays: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> in_ready && !mem_req && !rf_we);

  a_r12_jump_last: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |=> in_ready);

endmodule

bind pushpop_seq pushpop_seq_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/pushpop_seq_bench.sv
module pushpop_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [15:0] in_instr;
  logic        illegal;
  logic [4:0]  rf_raddr;
  logic [31:0] rf_rdata;
  logic        rf_we;
  logic [4:0]  rf_waddr;
  logic [31:0] rf_wdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_stall;
  logic        redir_valid;
  logic [31:0] redir_target;

  always #5 clk = ~clk;

  pushpop_seq u_pushpop_seq (.*);

  // {instruction, expected stack adjustment}: push/pop pairs over every list and extra value
  localparam logic [23:0] VEC [24] = '{
    24'hB84210, 24'hBA4210, 24'hB85620, 24'hBC5620,
    24'hB86A30, 24'hBE6A30, 24'hB87E40, 24'hBA7E40,
    24'hB88220, 24'hBC8220, 24'hB89630, 24'hBE9630,
    24'hB8AA40, 24'hBAAA40, 24'hB8BE50, 24'hBCBE50,
    24'hB8C230, 24'hBEC230, 24'hB8D640, 24'hBAD640,
    24'hB8EA50, 24'hBCEA50, 24'hB8FE70, 24'hBEFE70
  };

  logic [31:0] rf  [32];
  logic [31:0] mem [256];
  logic [31:0] m_rf  [32];
  logic [31:0] m_mem [256];

  int          total = 0, bad = 0, cyc = 0;
  int          acc_cnt = 0, side_cnt = 0, ill_cnt = 0, redir_cnt = 0;
  logic [31:0] got_tgt = '0;
  logic        init_go = 1'b0, scr_go = 1'b0, stall_en = 1'b0;
  logic [31:0] scr_seed = '0;
  logic [7:0]  lfsr = 8'h5A;

  function automatic logic [31:0] mix(input logic [31:0] s, input int i);
    return (s ^ (32'(i) * 32'h9E3779B9)) * 32'h00010003 + 32'(i);
  endfunction

  assign rf_rdata  = (rf_raddr == 5'd0) ? 32'd0 : rf[rf_raddr];
  assign mem_rdata = mem[mem_addr[9:2]];

  // environment: register file, memory, event counters
  always @(posedge clk) begin
    if (init_go) begin
      for (int i = 0; i < 32; i++) rf[i] <= (i == 0) ? 32'd0 : (i == 2) ? 32'h200 : mix(32'h1234, i);
      for (int i = 0; i < 256; i++) mem[i] <= 32'hA5000000 + 32'(i);
    end else if (scr_go) begin
      for (int i = 1; i < 32; i++) if (i != 2) rf[i] <= mix(scr_seed, i);
    end else begin
      if (rf_we && rf_waddr != 5'd0) rf[rf_waddr] <= rf_wdata;
      if (mem_req && mem_we && !mem_stall) mem[mem_addr[9:2]] <= mem_wdata;
    end
    if (mem_req && !mem_stall) acc_cnt <= acc_cnt + 1;
    if (rf_we || mem_req)      side_cnt <= side_cnt + 1;
    if (illegal)               ill_cnt <= ill_cnt + 1;
    if (redir_valid) begin
      redir_cnt <= redir_cnt + 1;
      got_tgt   <= redir_target;
    end
  end

  always @(negedge clk) begin
    lfsr      <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_stall <= stall_en && lfsr[0];
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // behavioural reference
  task automatic model_run(input logic [15:0] ins, output bit redir, output logic [31:0] tgt, output int nacc);
    int ord [13] = '{1, 8, 9, 18, 19, 20, 21, 22, 23, 24, 25, 26, 27};
    bit sel [32];
    int n, base, adj;
    logic [31:0] a, t1, t2;
    int sa, sb;
    redir = 0; tgt = '0; nacc = 0;
    if (ins[12:10] == 3'b011) begin
      sa = (ins[9:8] == 2'b00) ? int'(ins[9:7]) + 8 : int'(ins[9:7]) + 16;
      sb = (ins[4:3] == 2'b00) ? int'(ins[4:2]) + 8 : int'(ins[4:2]) + 16;
      if (!ins[6]) begin
        t1 = m_rf[10]; t2 = m_rf[11]; m_rf[sa] = t1; m_rf[sb] = t2;
      end else begin
        t1 = m_rf[sa]; t2 = m_rf[sb]; m_rf[10] = t1; m_rf[11] = t2;
      end
      return;
    end
    n = (ins[7:4] == 4'hF) ? 13 : int'(ins[7:4]) - 3;
    base = (n == 13) ? 64 : (n >= 9) ? 48 : (n >= 5) ? 32 : 16;
    adj = base + 16 * int'(ins[3:2]);
    for (int i = 0; i < 32; i++) sel[i] = 0;
    for (int k = 0; k < n; k++) sel[ord[k]] = 1;
    nacc = n;
    if (ins[10:9] == 2'b00) begin
      a = m_rf[2];
      for (int i = 31; i > 0; i--) if (sel[i]) begin a -= 4; m_mem[a[9:2]] = m_rf[i]; end
      m_rf[2] = m_rf[2] - 32'(adj);
    end else begin
      a = m_rf[2] + 32'(adj);
      for (int i = 31; i > 0; i--) if (sel[i]) begin a -= 4; m_rf[i] = m_mem[a[9:2]]; end
      if (ins[10:9] == 2'b10) m_rf[10] = '0;
      m_rf[2] = m_rf[2] + 32'(adj);
      redir = ins[10:9] != 2'b01;
      tgt = m_rf[1];
    end
  endtask

  task automatic compare_state(input string req);
    bit ok = 1;
    logic [31:0] av = '0, ev = '0;
    for (int i = 0; i < 32; i++) if (ok && rf[i] !== m_rf[i]) begin ok = 0; av = rf[i]; ev = m_rf[i]; end
    for (int i = 0; i < 256; i++) if (ok && mem[i] !== m_mem[i]) begin ok = 0; av = mem[i]; ev = m_mem[i]; end
    check(ok, req, av, ev);
  endtask

  task automatic scramble(input logic [31:0] seed);
    @(negedge clk);
    scr_seed = seed; scr_go = 1'b1;
    @(negedge clk);
    scr_go = 1'b0;
    for (int i = 1; i < 32; i++) if (i != 2) m_rf[i] = mix(seed, i);
  endtask

  task automatic issue(input logic [15:0] ins, output bit busy_after, output bit redir_last);
    int n = 0;
    bit prev;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_instr = ins;
    @(negedge clk);
    in_valid = 1'b0;
    busy_after = !in_ready;
    prev = redir_valid;
    while (!in_ready && n < 500) begin
      prev = redir_valid;
      @(negedge clk);
      n++;
    end
    redir_last = prev;
    if (n >= 500) check(0, "R11 hang", 32'(n), 32'd0);
  endtask

  task automatic run_pp(input logic [15:0] ins, input logic [7:0] adj, input string tag);
    bit er, busy, rl; logic [31:0] et, sp0; int na, acc0, rc0;
    if (ins[10:9] != 2'b00) scramble(mix(32'(ins), cyc));
    sp0 = m_rf[2];
    model_run(ins, er, et, na);
    acc0 = acc_cnt; rc0 = redir_cnt;
    issue(ins, busy, rl);
    compare_state(ins[10:9] == 2'b00 ? {tag, " R3 push contents"} : {tag, " R4 pop contents"});
    check(rf[2] == (ins[10:9] == 2'b00 ? sp0 - 32'(adj) : sp0 + 32'(adj)), "R2 stack adjustment",
          rf[2], ins[10:9] == 2'b00 ? sp0 - 32'(adj) : sp0 + 32'(adj));
    check(acc_cnt - acc0 == na, "R1 access count", 32'(acc_cnt - acc0), 32'(na));
    check(busy, "R11 busy after accept", 32'(busy), 32'd1);
    check((redir_cnt - rc0) == (er ? 1 : 0), "R6 redirect count", 32'(redir_cnt - rc0), 32'(er));
    if (er) begin
      check(got_tgt == et, "R6 redirect target", got_tgt, et);
      check(rl, "R12 redirect last", 32'(rl), 32'd1);
    end
    if (ins[10:9] == 2'b10) check(rf[10] == 32'd0, "R5 x10 zero", rf[10], 32'd0);
  endtask

  initial begin
    bit er, busy, rl; logic [31:0] et; int na, s0, i0;
    rst_n = 1'b0; in_valid = 1'b0; in_instr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready && !mem_req && !rf_we && !redir_valid && !illegal, "R11 reset state",
          {27'd0, in_ready, mem_req, rf_we, redir_valid, illegal}, 32'h10);

    init_go = 1'b1;
    @(negedge clk);
    init_go = 1'b0;
    for (int i = 0; i < 32; i++) m_rf[i] = (i == 0) ? 32'd0 : (i == 2) ? 32'h200 : mix(32'h1234, i);
    for (int i = 0; i < 256; i++) m_mem[i] = 32'hA5000000 + 32'(i);

    for (int e = 0; e < 24; e++) run_pp(VEC[e][23:8], VEC[e][7:0], "table");

    // R10: memory stalls on arbitrary steps
    stall_en = 1'b1;
    for (int e = 12; e < 24; e++) run_pp(VEC[e][23:8], VEC[e][7:0], "R10 stalled");
    stall_en = 1'b0;

    // R7 and R8: moves over every selector value
    for (int r = 0; r < 8; r++) begin
      logic [15:0] mv = 16'hAC22 | 16'(r << 7) | 16'((7 - r) << 2);
      scramble(32'h77 + 32'(r));
      model_run(mv, er, et, na);
      issue(mv, busy, rl);
      compare_state("R7 R8 move to saved");
      scramble(32'h99 + 32'(r));
      model_run(mv | 16'h0040, er, et, na);
      issue(mv | 16'h0040, busy, rl);
      compare_state("R7 R8 move from saved");
    end

    // R9: reserved lists and foreign encodings
    for (int r = 0; r < 4; r++) begin
      logic [15:0] bad_ins [2];
      bad_ins[0] = 16'hB802 | 16'(r << 4);
      bad_ins[1] = 16'hBE02 | 16'(r << 4);
      for (int k = 0; k < 2; k++) begin
        s0 = side_cnt; i0 = ill_cnt;
        issue(bad_ins[k], busy, rl);
        check(ill_cnt - i0 == 1, "R9 illegal pulse", 32'(ill_cnt - i0), 32'd1);
        check(side_cnt == s0, "R9 no side effect", 32'(side_cnt - s0), 32'd0);
      end
    end
    s0 = side_cnt; i0 = ill_cnt;
    issue(16'hB942, busy, rl);
    issue(16'hAC02, busy, rl);
    check(ill_cnt - i0 == 2, "R9 foreign encodings", 32'(ill_cnt - i0), 32'd2);
    check(side_cnt == s0, "R9 foreign no effect", 32'(side_cnt - s0), 32'd0);
    compare_state("R9 state unchanged");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule